// File: doc/BRIEF.md
# Streaming Two-Digit Bank Maximum Accumulator

This block reads a stream of ASCII characters, one byte per clock with a valid strobe. Line feeds divide the stream into banks. From the digits '1' to '9' of each bank, taken in stream order, it keeps the largest two-digit number whose tens digit comes before its ones digit. It does this in a single pass, holding only two digit registers. The pair is refined as each new digit arrives, so the bank is never stored or searched.

When a bank closes, the block adds that bank's best pair to a 32-bit running total. When the end-of-transmission byte arrives, the block presents the total on its output in the same cycle, together with a one-cycle valid pulse. After that it ignores all input until the next reset. The block sits after a byte receiver in a puzzle-solving datapath. It never stalls the stream.

Top module: `bank_pair_summer`

## Requirements
- R1: After reset, and on every accepted byte other than 0x04, `total_valid` is low.
- R2: An accepted byte from 0x31 to 0x39 is a digit whose value is the byte minus 0x30. The first digit of a bank loads the tens register and the second loads the ones register.
- R3: When a later digit arrives in a bank and tens < ones, the old ones value moves to tens and the new digit becomes ones.
- R4: When a later digit arrives and tens >= ones, the ones register takes the new digit only if the new digit is larger. Together, R2 to R4 give the largest ordered pair in the bank.
- R5: An accepted line feed (0x0A) adds 10*tens+ones to the running total and restarts the pair. A bank with fewer than two digits adds 0.
- R6: An accepted 0x04 raises `total_valid` in that same cycle. In that cycle `total` equals the running total plus the value of the still-open bank, if that bank holds at least two digits.
- R7: A byte with `in_valid` low has no effect. An accepted byte that is not a digit 1 to 9, a line feed or 0x04 also has no effect; this includes '0', space, CR and letters.
- R8: After the first 0x04, all input is ignored. `total_valid` stays low and `total` holds the final value until reset.
- R9: The block accepts bytes on consecutive clocks with no stall. Any number of idle cycles between bytes gives the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | `in_byte` holds a character this cycle |
| in_byte | input | 8 | ASCII character |
| total_valid | output | 1 | One-cycle pulse: `total` is final |
| total | output | 32 | Sum of bank maxima (open bank included while valid) |

## Verification
The end-of-transmission byte can close a bank and present the total in the same cycle. When the last bank has no trailing line feed, its pair must be folded into `total` combinationally while `total_valid` is high. Streams that end this way are provoked, as are streams whose open bank holds zero or one digit. Each is judged against a total that the bench computes by brute-force search over every ordered digit pair in each bank. The same streams are replayed with idle gaps and with invalid bytes, and must give identical totals.

// File: rtl/bank_pair_pkg.sv
// Package: shared constants and types for the bank pair accumulator.
// Assumes 8-bit ASCII input and decimal digits 1..9.
package bank_pair_pkg;
    localparam int BYTE_W  = 8;
    localparam int DIGIT_W = 4;
    localparam int PAIR_MAX = 99;
    localparam int PAIR_W  = $clog2(PAIR_MAX + 1);

    localparam logic [BYTE_W-1:0] CH_LF   = 8'h0A;
    localparam logic [BYTE_W-1:0] CH_EOT  = 8'h04;
    localparam logic [BYTE_W-1:0] CH_ZERO = 8'h30;
    localparam logic [BYTE_W-1:0] CH_ONE  = 8'h31;
    localparam logic [BYTE_W-1:0] CH_NINE = 8'h39;

    // Fill state of the current bank's digit pair
    typedef enum logic [1:0] {
        FILL_NONE = 2'd0,
        FILL_TENS = 2'd1,
        FILL_FULL = 2'd2
    } pair_fill_t;
endpackage

// File: rtl/bank_byte_classify.sv
// Module: bank_byte_classify
// Turns an accepted byte into at most one strobe: digit, end of bank or end of stream.
// Assumes the caller gates with run_done so that no strobe fires after the stream ends.
module bank_byte_classify
    import bank_pair_pkg::*;
(
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_byte,
    input  logic               run_done,
    output logic               dig_stb,
    output logic [DIGIT_W-1:0] dig_val,
    output logic               eob_stb,
    output logic               eot_stb
);
    logic             take;
    logic [BYTE_W-1:0] offset;

    // Decode the byte class and the digit value
    always_comb begin
        take    = in_valid && !run_done;
        offset  = in_byte - CH_ZERO;
        dig_val = offset[DIGIT_W-1:0];
        dig_stb = take && (in_byte >= CH_ONE) && (in_byte <= CH_NINE);
        eob_stb = take && (in_byte == CH_LF);
        eot_stb = take && (in_byte == CH_EOT);
    end
endmodule

// File: rtl/bank_pair_tracker.sv
// Module: bank_pair_tracker
// Keeps the best ordered digit pair of the current bank in one streaming pass.
// Assumes digits are 1..9 and that clear and dig_stb never coincide.
module bank_pair_tracker
    import bank_pair_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dig_stb,
    input  logic [DIGIT_W-1:0] dig_val,
    input  logic               clear,
    output logic               pair_full,
    output logic [PAIR_W-1:0]  pair_val
);
    pair_fill_t         fill_q;
    logic [DIGIT_W-1:0] tens_q;
    logic [DIGIT_W-1:0] ones_q;

    // Load, promote or replace the digit pair as each digit arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= FILL_NONE;
            tens_q <= '0;
            ones_q <= '0;
        end else if (clear) begin
            fill_q <= FILL_NONE;
            tens_q <= '0;
            ones_q <= '0;
        end else if (dig_stb) begin
            case (fill_q)
                FILL_NONE: begin
                    tens_q <= dig_val;
                    fill_q <= FILL_TENS;
                end
                FILL_TENS: begin
                    ones_q <= dig_val;
                    fill_q <= FILL_FULL;
                end
                default: begin
                    if (tens_q < ones_q) begin
                        tens_q <= ones_q;
                        ones_q <= dig_val;
                    end else if (ones_q < dig_val) begin
                        ones_q <= dig_val;
                    end
                end
            endcase
        end
    end

    // Present the pair value once both digits are loaded
    always_comb begin
        pair_full = (fill_q == FILL_FULL);
        pair_val  = PAIR_W'(tens_q) * PAIR_W'(10) + PAIR_W'(ones_q);
    end

    // R2: a full pair never holds a zero digit
    assert_pair_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pair_full |-> (tens_q != '0 && ones_q != '0));

    // R3 and R4: a later digit never lowers the pair value
    assert_pair_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_stb && pair_full && !clear) |=> (pair_val >= $past(pair_val)));

    // R5: a bank end restarts the pair
    assert_pair_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill_q == FILL_NONE));

    // R7: without a digit or clear the pair holds
    assert_pair_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dig_stb && !clear) |=> ($stable(tens_q) && $stable(ones_q) && $stable(fill_q)));
endmodule

// File: rtl/bank_sum_accum.sv
// Module: bank_sum_accum
// Adds each closed bank's pair to the running total and ends the run on end of stream.
// Assumes eob_stb and eot_stb are mutually exclusive; the sum wraps modulo 2**SUM_W.
module bank_sum_accum
    import bank_pair_pkg::*;
#(
    parameter int SUM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eob_stb,
    input  logic              eot_stb,
    input  logic              pair_full,
    input  logic [PAIR_W-1:0] pair_val,
    output logic [SUM_W-1:0]  total,
    output logic              total_valid,
    output logic              run_done
);
    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] pending;
    logic             done_q;

    // Fold the open bank's pair into the presented total
    always_comb begin
        pending     = pair_full ? SUM_W'(pair_val) : '0;
        total       = sum_q + pending;
        total_valid = eot_stb;
        run_done    = done_q;
    end

    // Accumulate on bank end and latch completion on stream end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (eob_stb || eot_stb) begin
                sum_q <= total;
            end
            if (eot_stb) begin
                done_q <= 1'b1;
            end
        end
    end

    // R5: a bank with fewer than two digits adds nothing
    assert_short_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eob_stb && !pair_full) |=> $stable(sum_q));

    // R6: a valid total ends the run
    assert_valid_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        total_valid |=> done_q);

    // R8: completion is sticky and silences the output
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> (done_q && $stable(sum_q)));
    assert_quiet_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !total_valid);
endmodule

// File: rtl/bank_pair_summer.sv
// Module: bank_pair_summer (top)
// Sums the best ordered two-digit pair of every line of an ASCII stream.
// Assumes one byte per clock at most; it runs once per reset.
module bank_pair_summer
    import bank_pair_pkg::*;
#(
    parameter int SUM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             total_valid,
    output logic [SUM_W-1:0] total
);
    logic               dig_stb;
    logic [DIGIT_W-1:0] dig_val;
    logic               eob_stb;
    logic               eot_stb;
    logic               run_done;
    logic               pair_full;
    logic [PAIR_W-1:0]  pair_val;

    bank_byte_classify u_classify (
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .run_done (run_done),
        .dig_stb  (dig_stb),
        .dig_val  (dig_val),
        .eob_stb  (eob_stb),
        .eot_stb  (eot_stb)
    );

    bank_pair_tracker u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .dig_stb   (dig_stb),
        .dig_val   (dig_val),
        .clear     (eob_stb || eot_stb),
        .pair_full (pair_full),
        .pair_val  (pair_val)
    );

    bank_sum_accum #(.SUM_W(SUM_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .eob_stb     (eob_stb),
        .eot_stb     (eot_stb),
        .pair_full   (pair_full),
        .pair_val    (pair_val),
        .total       (total),
        .total_valid (total_valid),
        .run_done    (run_done)
    );

    // R7: each byte is at most one kind of event
    assert_one_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dig_stb, eob_stb, eot_stb}));

    // R1: the total is only flagged for an end-of-stream byte
    assert_valid_only_eot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        total_valid |-> (in_valid && in_byte == CH_EOT));
endmodule

// File: tb/bank_pair_summer_bench.sv
// Directed bench: each task resets, streams a scenario and checks it against a brute-force model.
module bank_pair_summer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        total_valid;
    logic [31:0] total;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] eot_total;
    logic        eot_valid;

    bank_pair_summer u_bank_pair_summer (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .total_valid (total_valid),
        .total       (total)
    );

    always #4 clk = ~clk;

    initial begin
        #(200000 * 8);
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Brute-force best ordered pair of a bank
    function automatic int best_pair(input int d[$]);
        int best = 0;
        for (int i = 0; i < d.size(); i++)
            for (int j = i + 1; j < d.size(); j++)
                if (10 * d[i] + d[j] > best) best = 10 * d[i] + d[j];
        return best;
    endfunction

    // Model total: banks closed by LF and by the final end of stream
    function automatic longint model_total(input string s);
        int bank[$];
        longint sum = 0;
        for (int k = 0; k < s.len(); k++) begin
            if (s[k] >= "1" && s[k] <= "9") bank.push_back(int'(s[k]) - 48);
            else if (s[k] == 8'h0A) begin
                sum += best_pair(bank);
                bank.delete();
            end
        end
        sum += best_pair(bank);
        return sum;
    endfunction

    // Drive one accepted byte; check R1 or capture the EOT result
    task automatic send_byte(input logic [7:0] b, input string req);
        @(negedge clk);
        in_byte  = b;
        in_valid = 1'b1;
        #1;
        if (b == 8'h04) begin
            eot_valid = total_valid;
            eot_total = total;
        end else begin
            check(total_valid == 1'b0, {req, " R1 valid low on non-EOT byte"}, total_valid, 0);
        end
    endtask

    // Drive idle cycles with a digit on the bus but valid low (R7)
    task automatic send_idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = "9";
            #1;
            check(total_valid == 1'b0, "R7 idle cycle valid low", total_valid, 0);
        end
    endtask

    // Stream a scenario followed by EOT and check the total
    task automatic run_stream(input string s, input int gap, input string req);
        longint exp;
        exp = model_total(s);
        do_reset();
        for (int k = 0; k < s.len(); k++) begin
            send_byte(s[k], req);
            if (gap > 0) send_idle(gap);
        end
        send_byte(8'h04, req);
        check(eot_valid == 1'b1, {req, " R6 valid with EOT"}, eot_valid, 1);
        check(eot_total == exp[31:0], {req, " total"}, eot_total, exp);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(total_valid == 1'b0, "R1 reset valid low", total_valid, 0);
    endtask

    task automatic t_init_pair();
        run_stream("47\n", 0, "R2 first two digits");
        check(eot_total == 47, "R2 pair 47", eot_total, 47);
    endtask

    task automatic t_promote();
        run_stream("18111\n", 0, "R3 promote");
        check(eot_total == 81, "R3 promote gives 81", eot_total, 81);
        run_stream("811111111111119\n234234234234278\n", 0, "R3 long banks");
    endtask

    task automatic t_replace();
        run_stream("9125\n", 0, "R4 replace ones");
        check(eot_total == 95, "R4 gives 95", eot_total, 95);
        run_stream("987654321111111\n818181911112111\n", 0, "R4 multi bank");
    endtask

    task automatic t_short_banks();
        run_stream("5\n\n34\n7\n", 0, "R5 short banks");
        check(eot_total == 34, "R5 short banks add zero", eot_total, 34);
    endtask

    task automatic t_open_bank();
        run_stream("91\n19", 0, "R6 open bank");
        check(eot_total == 110, "R6 open bank folded", eot_total, 110);
        run_stream("91\n1", 0, "R6 one-digit open bank");
        check(eot_total == 91, "R6 one-digit open bank adds 0", eot_total, 91);
    endtask

    task automatic t_ignore();
        run_stream("9 x0\r8\n", 1, "R7 ignored bytes");
        check(eot_total == 98, "R7 ignored bytes give 98", eot_total, 98);
    endtask

    task automatic t_once();
        logic [31:0] final_total;
        run_stream("65\n", 0, "R8 first run");
        final_total = eot_total;
        send_byte("9", "R8 after end");
        send_byte("9", "R8 after end");
        send_byte(8'h0A, "R8 after end");
        send_byte(8'h04, "R8 after end");
        check(eot_valid == 1'b0, "R8 second EOT valid low", eot_valid, 0);
        check(eot_total == final_total, "R8 total held", eot_total, final_total);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(total == 65, "R8 total holds final value", total, 65);
    endtask

    task automatic t_gaps();
        run_stream("3141592653\n2718281828\n", 3, "R9 with gaps");
        check(eot_total == 96 + 88, "R9 gap result", eot_total, 184);
        run_stream("3141592653\n2718281828\n", 0, "R9 back to back");
        check(eot_total == 184, "R9 back to back result", eot_total, 184);
    endtask

    initial begin
        t_reset();
        t_init_pair();
        t_promote();
        t_replace();
        t_short_banks();
        t_open_bank();
        t_ignore();
        t_once();
        t_gaps();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule